// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a single counter stage of parameterizable width (four bits by default) that counts upward in plain binary and wraps to zero after its all-ones value. A stage can be preset from a parallel data input on a clock edge. It can also be cleared, advanced or left holding its value. Every change of the count happens on the rising clock edge, except for the clear when the stage is built with an asynchronous clear.

Two count enables with different roles let stages be chained into one wide, fully synchronous counter. The local enable `cnt_en` gates only the increment. The chain enable `carry_in` gates the increment and also qualifies the combinational `carry_out` flag, which is raised when the stage holds all ones. Wiring each stage's `carry_out` to the next stage's `carry_in` and driving every `cnt_en` from one common enable makes the chain advance as a single counter. The parameter `ASYNC_CLR` is fixed at elaboration and selects whether the active-low clear acts at once or on the next rising edge.

Top module: `presettable_counter`

## Requirements
- R1: The count advances in binary modulo 2^WIDTH, so an increment from all ones (15 for WIDTH=4) gives 0.
- R2: With ASYNC_CLR=1, a low `clr_n` forces `count` to 0 at once, with no clock edge. With ASYNC_CLR=0, a low `clr_n` leaves `count` unchanged until the next rising edge, which sets it to 0.
- R3: With `clr_n` high and `ld_n` low, the rising edge copies `preset` into `count`, whatever the values of `cnt_en` and `carry_in`.
- R4: With `clr_n` and `ld_n` high and both `cnt_en` and `carry_in` high, the rising edge raises `count` by one.
- R5: With `clr_n` and `ld_n` high and either `cnt_en` or `carry_in` low, `count` keeps its value across the edge.
- R6: `carry_out` is high exactly when `count` is all ones and `carry_in` is high. It does not depend on `cnt_en`, and it follows `carry_in` with no clock edge.
- R7: When stages share one `cnt_en`, and each stage's `carry_out` drives the next stage's `carry_in`, the concatenated counts behave as one binary counter of the combined width, including the wrap from all ones to zero.
- R8: Precedence on an edge is clear first, then load, then count, then hold. A clear wins over a simultaneous load, and a load wins over a simultaneous count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLR |
| ld_n | input | 1 | Active-low parallel load enable |
| preset | input | WIDTH | Parallel load value |
| cnt_en | input | 1 | Local count enable |
| carry_in | input | 1 | Chain count enable; also qualifies carry_out |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High when count is all ones and carry_in is high |

## Verification
The checker module checks the per-edge behaviour on every cycle. This covers load, increment with wrap, hold when either enable is low, the carry flag against the count and the chain enable, and the clear for the selected style. Other behaviours can only be shown by bench scenarios. These are the instant clear taking effect between edges, the synchronous clear not acting before its edge, `carry_out` following `carry_in` within a half cycle, and a three-stage chain that stays one coherent 12-bit counter over hundreds of cycles and across its full wrap.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  // Action taken by a stage on the next rising edge, in precedence order.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } cnt_act_e;

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic     clr_n,
  input  logic     ld_n,
  input  logic     cnt_en,
  input  logic     carry_in,
  output cnt_act_e act
);

  // Strict priority: clear, load, count, hold.
  always_comb begin
    if (!clr_n)                 act = ACT_CLEAR;
    else if (!ld_n)             act = ACT_LOAD;
    else if (cnt_en && carry_in) act = ACT_COUNT;
    else                        act = ACT_HOLD;
  end

endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_act_e         act,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = preset;
      ACT_COUNT: nxt = cur + ONE;   // natural wrap modulo 2^WIDTH
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_sync
      // Clear already folded into d by the decoder.
      always_ff @(posedge clk) begin
        q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/cnt_term_det.sv
module cnt_term_det #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             carry_in,
  output logic             carry_out
);

  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  assign carry_out = carry_in && (cur == TOP_VAL);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             cnt_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);

  cnt_act_e         act;
  logic [WIDTH-1:0] nxt;

  cnt_mode_dec u_dec (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .cnt_en   (cnt_en),
    .carry_in (carry_in),
    .act      (act)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .act    (act),
    .cur    (count),
    .preset (preset),
    .nxt    (nxt)
  );

  cnt_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (nxt),
    .q     (count)
  );

  cnt_term_det #(.WIDTH(WIDTH)) u_term (
    .cur       (count),
    .carry_in  (carry_in),
    .carry_out (carry_out)
  );

endmodule

// File: rtl/counter_checker.sv
module counter_checker #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ld_n,
  input logic [WIDTH-1:0] preset,
  input logic             cnt_en,
  input logic             carry_in,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);

  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  logic started;
  logic clr_q;

  always_ff @(posedge clk) begin
    started <= 1'b1;
    clr_q   <= clr_n;
    if (ASYNC_CLR) begin
      // R2: with an instant clear, a low clear seen at an edge means zero already
      if (!clr_n) assert_clear_async_R2: assert (count == '0);
    end else begin
      // R2/R8: clear seen on the previous edge must have zeroed the count
      if (started && !clr_q) assert_clear_sync_R2: assert (count == '0);
    end
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> count == $past(preset));

  assert_incr_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && carry_in) |=> count == WIDTH'($past(count) + 1'b1));

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && carry_in && count == TOP_VAL) |=> count == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(cnt_en && carry_in)) |=> $stable(count));

  assert_carry_gate_R6: assert property (@(posedge clk) disable iff (!clr_n)
    !carry_in |-> !carry_out);

  assert_carry_top_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (carry_in && count == TOP_VAL) |-> carry_out);

  assert_carry_only_top_R6: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> count == TOP_VAL);

endmodule

bind presettable_counter counter_checker #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .ld_n      (ld_n),
  .preset    (preset),
  .cnt_en    (cnt_en),
  .carry_in  (carry_in),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/presettable_counter_bench.sv
module presettable_counter_bench;

  localparam int W      = 4;
  localparam int STAGES = 3;
  localparam int CW     = W * STAGES;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Asynchronous-clear unit under test
  logic         clr_n = 1'b0, ld_n = 1'b1, cnt_en = 1'b0, carry_in = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         carry_out;

  presettable_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) u_presettable_counter (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .preset(preset),
    .cnt_en(cnt_en), .carry_in(carry_in), .count(count), .carry_out(carry_out));

  // Synchronous-clear unit
  logic         s_clr_n = 1'b0, s_ld_n = 1'b1, s_en = 1'b0, s_cin = 1'b0;
  logic [W-1:0] s_preset = '0;
  logic [W-1:0] s_count;
  logic         s_cout;

  presettable_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) u_sync (
    .clk(clk), .clr_n(s_clr_n), .ld_n(s_ld_n), .preset(s_preset),
    .cnt_en(s_en), .carry_in(s_cin), .count(s_count), .carry_out(s_cout));

  // Chain of synchronous-clear stages
  logic          c_clr_n = 1'b0, c_ld_n = 1'b1, c_go = 1'b0;
  logic [CW-1:0] c_preset = '0;
  logic [CW-1:0] c_count;
  logic [STAGES-1:0] c_cout;

  for (genvar i = 0; i < STAGES; i++) begin : g_chain
    logic cin;
    if (i == 0) begin : g_first
      assign cin = c_go;
    end else begin : g_rest
      assign cin = c_cout[i-1];
    end
    presettable_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) u_stage (
      .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .preset(c_preset[W*i +: W]),
      .cnt_en(c_go), .carry_in(cin), .count(c_count[W*i +: W]),
      .carry_out(c_cout[i]));
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Vector: {clr_n, ld_n, cnt_en, carry_in, preset[3:0], exp_count[3:0], exp_carry}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {4'b1000, 4'hD, 4'hD, 1'b0},  // R3 load, enables low
    {4'b1111, 4'h0, 4'hE, 1'b0},  // R4 increment
    {4'b1111, 4'h0, 4'hF, 1'b1},  // R4/R6 reach top, carry up
    {4'b1101, 4'h0, 4'hF, 1'b1},  // R5 hold, R6 carry ignores cnt_en
    {4'b1110, 4'h0, 4'hF, 1'b0},  // R5 hold, R6 carry gated by carry_in
    {4'b1111, 4'h0, 4'h0, 1'b0},  // R1 wrap
    {4'b1011, 4'h5, 4'h5, 1'b0},  // R8 load beats count
    {4'b1111, 4'h0, 4'h6, 1'b0},  // R4
    {4'b1011, 4'hF, 4'hF, 1'b1},  // R3 load top value
    {4'b0011, 4'h3, 4'h0, 1'b0},  // R8 clear beats load
    {4'b1100, 4'h0, 4'h0, 1'b0},  // R5 hold at zero
    {4'b1111, 4'h0, 4'h1, 1'b0}   // R4
  };

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R2 reset async", 32'(count), 32'h0);
    check("R2 reset sync", 32'(s_count), 32'h0);
    check("R6 reset carry", 32'(carry_out), 32'h0);
    @(negedge clk);
    clr_n = 1'b1; s_clr_n = 1'b1; c_clr_n = 1'b1;

    // Vector walk on the asynchronous-clear unit
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {clr_n, ld_n, cnt_en, carry_in} = VEC[v][12:9];
      preset = VEC[v][8:5];
      @(posedge clk);
      #2;
      check($sformatf("R1-R8 vector %0d count", v), 32'(count), 32'(VEC[v][4:1]));
      check($sformatf("R6 vector %0d carry", v), 32'(carry_out), 32'(VEC[v][0]));
    end

    // R2: instant clear between edges
    @(negedge clk);
    clr_n = 1'b1; ld_n = 1'b0; preset = 4'h7; cnt_en = 1'b0; carry_in = 1'b0;
    @(posedge clk); #2;
    check("R3 load 7", 32'(count), 32'h7);
    @(negedge clk);
    clr_n = 1'b0; preset = 4'hA;
    #1;
    check("R2 async clear without edge", 32'(count), 32'h0);
    @(posedge clk); #2;
    check("R8 async clear holds over load", 32'(count), 32'h0);
    @(negedge clk);
    clr_n = 1'b1; ld_n = 1'b1;

    // R6: carry follows carry_in combinationally
    @(negedge clk);
    ld_n = 1'b0; preset = 4'hF;
    @(posedge clk); #2;
    @(negedge clk);
    ld_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b0;
    #1;
    check("R6 carry low with carry_in low", 32'(carry_out), 32'h0);
    carry_in = 1'b1;
    #1;
    check("R6 carry rises without edge", 32'(carry_out), 32'h1);
    cnt_en = 1'b1;
    #1;
    check("R6 carry independent of cnt_en", 32'(carry_out), 32'h1);
    cnt_en = 1'b0;

    // Synchronous-clear unit
    @(negedge clk);
    s_ld_n = 1'b0; s_preset = 4'h9;
    @(posedge clk); #2;
    check("R3 sync load 9", 32'(s_count), 32'h9);
    @(negedge clk);
    s_clr_n = 1'b0; s_preset = 4'h4; s_en = 1'b1; s_cin = 1'b1;
    #1;
    check("R2 sync clear waits for edge", 32'(s_count), 32'h9);
    @(posedge clk); #2;
    check("R8 sync clear beats load and count", 32'(s_count), 32'h0);
    @(negedge clk);
    s_clr_n = 1'b1; s_ld_n = 1'b1;
    @(posedge clk); #2;
    check("R4 sync count after clear", 32'(s_count), 32'h1);

    // Chain as one wide counter
    @(negedge clk);
    c_ld_n = 1'b0; c_preset = '0;
    @(posedge clk); #2;
    check("R7 chain load", 32'(c_count), 32'h0);
    @(negedge clk);
    c_ld_n = 1'b1; c_go = 1'b1;
    repeat (300) @(posedge clk);
    @(negedge clk);
    c_go = 1'b0;
    check("R7 chain after 300 counts", 32'(c_count), 32'd300);
    c_ld_n = 1'b0; c_preset = CW'(12'hFFE);
    @(posedge clk); #2;
    @(negedge clk);
    c_ld_n = 1'b1; c_go = 1'b1;
    @(posedge clk); #2;
    check("R7 chain reaches all ones", 32'(c_count), 32'hFFF);
    check("R7 chain top carry", 32'(c_cout[STAGES-1]), 32'h1);
    @(posedge clk); #2;
    check("R1 R7 chain wraps", 32'(c_count), 32'h0);
    @(negedge clk);
    c_go = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule